// File: doc/BRIEF.md
# Boolean sensitivity counter

This block takes an N-bit point `x` and a fixed Boolean function of N inputs. The function is supplied as a truth-table parameter of 2^N bits, where bit `v` of the table is the function value at input `v`. The block finds every input whose single-bit inversion changes the function value. It reports those inputs as a difference vector. It also reports how many there are, which is the sensitivity of the function at `x`.

One evaluator computes the function at the unmodified point. N further evaluators each compute it with exactly one bit inverted, and all other bits are shared with the original point. Each flipped result is XORed with the original result. The resulting mismatch bits are summed by a pairwise adder tree that works like a queue: the two oldest partial sums are added, and the result joins the tail of the queue. The point is captured on a one-cycle `start` pulse. The vector and the count are then registered and announced by a one-cycle `valid` flag.

Top module: `sens_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `valid`=0, `diff`=0 and `sens`=0.
- R2: `valid` is 1 in exactly the cycle after a cycle in which `start` was 1 at the rising edge, and 0 after any edge where `start` was 0.
- R3: When `valid` is 1, `diff[i]` equals TT[x] XOR TT[x with bit i inverted] for the `x` sampled with `start`. TT bit v is the function value at input v.
- R4: When `valid` is 1, `sens` equals the number of ones in `diff`.
- R5: After an edge with `start` low, `diff` and `sens` keep their values, whatever `x` does.
- R6: `sens` is ceil(log2(N+1)) bits wide and can reach N without wrapping. For parity over N=4 inputs it reads 4 with `diff`=4'b1111.
- R7: With N=1, `sens` is a single bit equal to `diff[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture `x` and compute on this edge |
| x | input | N | Input point |
| valid | output | 1 | One-cycle flag: results are fresh |
| diff | output | N | Per-input sensitivity bits |
| sens | output | ceil(log2(N+1)) | Count of ones in `diff` |

## Verification
The main instance uses a function in which input 0 always matters, inputs 1 and 2 each matter only when the other is 1, and input 3 never matters. The points tried cover each of these cases, so a wrong flip position, a stuck difference bit, or a miscount in the tree shows up as a specific mismatch. A parity instance drives every difference bit to 1, which checks the full-scale count of 4 and the width of the count. A one-input instance checks the degenerate tree that has no adders. Directed steps change `x` while `start` is low to show that the outputs hold. They also check reset and the single-cycle shape of `valid`.

// File: rtl/sens_pkg.sv
// Shared helpers for the sensitivity counter.
// Assumes widths are positive integers.
package sens_pkg;
    // Width needed to hold a count from 0 to n.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sens_tt_eval.sv
// Looks up a Boolean function of N inputs in a 2^N-bit truth table.
// Assumes bit v of TT is the function value at input pattern v.
module sens_tt_eval #(
    parameter int N = 4,
    parameter logic [(1<<N)-1:0] TT = '0
) (
    input  logic [N-1:0] pt,
    output logic         y
);
    // Purpose: index the table with the point.
    always_comb begin
        y = TT[pt];
    end
endmodule

// File: rtl/sens_flip_bank.sv
// Evaluates the function at x and at each single-bit inversion of x,
// then XORs each flipped result against the original.
// Assumes TT holds a complete table.
module sens_flip_bank #(
    parameter int N = 4,
    parameter logic [(1<<N)-1:0] TT = '0
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] diff
);
    localparam logic [N-1:0] ONE = N'(1);

    logic         base_y;
    logic [N-1:0] flip_y;

    sens_tt_eval #(.N(N), .TT(TT)) u_base (.pt(x), .y(base_y));

    for (genvar i = 0; i < N; i++) begin : g_flip
        logic [N-1:0] pt_i;
        // Purpose: share all bits except input i, which is inverted.
        always_comb begin
            pt_i = x ^ (ONE << i);
        end
        sens_tt_eval #(.N(N), .TT(TT)) u_eval (.pt(pt_i), .y(flip_y[i]));
        // Purpose: mark input i when its inversion changes the result.
        always_comb begin
            diff[i] = base_y ^ flip_y[i];
        end
    end
endmodule

// File: rtl/sens_pair_tree.sv
// Sums N single-bit inputs with a queue-ordered pairwise adder tree.
// Slots 0..N-1 hold the inputs. Slot N+k holds the sum of slots 2k and 2k+1,
// so each adder takes the two oldest entries and appends its result.
// Every slot is CW bits wide; narrower sums are zero-padded.
module sens_pair_tree #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] total
);
    localparam int SLOTS = 2 * N - 1;

    logic [CW-1:0] slot [SLOTS];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        // Purpose: zero-extend each leaf to the common width.
        always_comb begin
            slot[i] = CW'(bits[i]);
        end
    end

    for (genvar k = 0; k < N - 1; k++) begin : g_add
        // Purpose: add the two oldest queue entries and append the result.
        always_comb begin
            slot[N + k] = slot[2 * k] + slot[2 * k + 1];
        end
    end

    // Purpose: the last appended entry is the full count.
    always_comb begin
        total = slot[SLOTS - 1];
    end
endmodule

// File: rtl/sens_counter.sv
// Top level: reports which single-bit flips of x change f, and how many.
// x is sampled when start is 1. The results are registered, and valid
// pulses for one cycle after start. Reset is synchronous and active low.
module sens_counter #(
    parameter int N = 4,
    parameter logic [(1<<N)-1:0] TT = 16'h6A6A,
    localparam int CW = sens_pkg::cnt_width(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  x,
    output logic          valid,
    output logic [N-1:0]  diff,
    output logic [CW-1:0] sens
);
    logic [N-1:0]  diff_c;
    logic [CW-1:0] sens_c;

    sens_flip_bank #(.N(N), .TT(TT)) u_bank (.x(x), .diff(diff_c));
    sens_pair_tree #(.N(N), .CW(CW)) u_tree (.bits(diff_c), .total(sens_c));

    // Purpose: capture the results on start and pulse valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            diff  <= '0;
            sens  <= '0;
        end else begin
            valid <= start;
            if (start) begin
                diff <= diff_c;
                sens <= sens_c;
            end
        end
    end
endmodule

// File: rtl/sens_counter_chk.sv
// Property checker for sens_counter, attached to every instance by bind.
module sens_counter_chk #(
    parameter int N = 4,
    localparam int CW = sens_pkg::cnt_width(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          valid,
    input logic [N-1:0]  diff,
    input logic [CW-1:0] sens
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!valid && diff == '0 && sens == '0)); // R1
    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> valid); // R2
    AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !valid); // R2
    AST_COUNT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n) valid |-> (32'(sens) == $countones(diff))); // R4
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(diff) && $stable(sens))); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) 32'(sens) <= N); // R6
endmodule

bind sens_counter sens_counter_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .valid(valid), .diff(diff), .sens(sens)
);

// File: tb/sens_counter_bench.sv
module sens_counter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] x = '0;
    logic       x1 = 1'b0;

    logic       valid, valid_p, valid_1;
    logic [3:0] diff, diff_p;
    logic [2:0] sens, sens_p;
    logic [0:0] diff_1;
    logic [0:0] sens_1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // f = x0 ^ (x1 & x2); x3 is ignored
    sens_counter #(.N(4), .TT(16'h6A6A)) u_sens_counter (
        .clk(clk), .rst_n(rst_n), .start(start), .x(x),
        .valid(valid), .diff(diff), .sens(sens));
    // parity
    sens_counter #(.N(4), .TT(16'h6996)) u_sens_counter_par (
        .clk(clk), .rst_n(rst_n), .start(start), .x(x),
        .valid(valid_p), .diff(diff_p), .sens(sens_p));
    // one input, identity
    sens_counter #(.N(1), .TT(2'b10)) u_sens_counter_one (
        .clk(clk), .rst_n(rst_n), .start(start), .x(x1),
        .valid(valid_1), .diff(diff_1), .sens(sens_1));

    // {x, expected diff, expected sens}
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {4'd0,  4'b0001, 3'd1},
        {4'd6,  4'b0111, 3'd3},
        {4'd2,  4'b0101, 3'd2},
        {4'd4,  4'b0011, 3'd2},
        {4'd15, 4'b0111, 3'd3},
        {4'd9,  4'b0001, 3'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] xv);
        @(negedge clk);
        x = xv;
        x1 = xv[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", valid, 0);
        chk("R1 diff", diff, 0);
        chk("R1 sens", sens, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle valid", valid, 0);

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][10:7]);
            chk("R2 valid", valid, 1);
            chk("R3 diff", diff, VEC[i][6:3]);
            chk("R4 sens", sens, VEC[i][2:0]);
            chk("R6 parity sens", sens_p, 4);
            chk("R6 parity diff", diff_p, 15);
            chk("R7 one diff", diff_1, 1);
            chk("R7 one sens", sens_1, diff_1);
        end

        // R5: outputs hold while start is low
        pulse(4'd6);
        @(negedge clk);
        x = 4'd0;
        chk("R2 pulse ends", valid, 0);
        @(negedge clk);
        chk("R5 diff hold", diff, 7);
        chk("R5 sens hold", sens, 3);

        // back-to-back starts keep valid high
        @(negedge clk);
        x = 4'd2;
        start = 1'b1;
        @(negedge clk);
        x = 4'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R2 back-to-back valid", valid, 1);
        chk("R3 second point diff", diff, 1);
        chk("R4 second point sens", sens, 1);

        // R1: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset diff", diff, 0);
        chk("R1 reset sens", sens, 0);
        chk("R1 reset valid", valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule